// File: doc/BRIEF.md
# Flash Query and ID Responder

This block builds the read data returned by a bank of identical parallel flash devices while the bank is in query mode or in identification mode. The bank is described by three byte counts: the bank width on the bus, the width at which each device is wired, and the widest mode the device supports. From these counts the block works out how many devices share the bus. It shifts the incoming bus byte offset down to the device's own query addressing and then looks up either a byte of the query table or an identification word.

The single-device answer is widened when a wide part runs in byte mode, and is then copied into every device lane. A bus access wider than the bank is answered with one bank-width slice per successive bank word, packed from low byte to high. A command sequencer uses the block by presenting each read beat together with a mode bit and the bank geometry. The answer appears on a registered output one cycle later.

Top module: `flash_query_resp`

## Requirements
- R1: The table or ID index is the bus offset shifted right by log2(bank) + log2(max device) − log2(device width). Example: bank 2, device 1, max 2 maps offset 0x40 to index 0x10.
- R2: In query mode an index of 0x52 or above returns a zero byte.
- R3: Query table content: indices 0x10, 0x11 and 0x12 hold 0x51, 0x52, 0x59 ("QRY"), and 0x27 holds log2 of the device size in bytes. Index 0x2D/0x2E holds block count minus one and 0x2F/0x30 holds sector bytes divided by 256, each 16-bit little-endian (low byte first). All other indices hold zero.
- R4: In query mode with device width below max device width, the table byte fills every byte of the device lane. This holds only for device width 1 with bank width at most 4; any other such mismatch returns zero in query mode.
- R5: In query mode with device width equal to max device width, each device lane carries the table byte in its lowest byte and zero in its other bytes, and every device lane of the bank carries the same value.
- R6: In ID mode the low 8 bits of the index select the answer: 0 gives the manufacturer ID, 1 gives the device ID, and any other value gives zero. Byte j of every device lane is ID byte j (byte 0 is bits 7:0, byte 1 is bits 15:8, higher bytes zero).
- R7: When the access width exceeds the bank width, slice k (bytes k·bank up to k·bank+bank−1) is the answer for offset + k·bank.
- R8: Response bytes at or above the access width read as zero.
- R9: A configuration returns all-zero data if any of the following holds: a width is zero, is not a power of two, or exceeds the data path; the access width is not a power of two; the device width exceeds the bank width; or the device width exceeds the max device width.
- R10: rspValid is high exactly one cycle after each cycle with reqValid high, and rspData changes only in those cycles.
- R11: While and after reset, with no request yet, rspValid and rspData are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read beat present |
| reqIdMode | input | 1 | 1 selects ID answer, 0 selects query table |
| reqOffset | input | OFS_W | Bus byte offset of the beat |
| bankBytes | input | CFG_W | Bank width in bytes |
| devBytes | input | CFG_W | Wired device width in bytes |
| maxDevBytes | input | CFG_W | Widest device mode in bytes |
| accBytes | input | CFG_W | Access width in bytes |
| rspValid | output | 1 | Answer valid |
| rspData | output | 8*DATA_BYTES | Answer data, byte 0 in bits 7:0 |

## Verification
On every cycle the assertions check the one-cycle handshake, that the output holds between requests, that an illegal geometry yields zero data, and that a one-byte access leaves the upper bytes zero. The index rescaling, the table content, the byte-mode widening, the lane copying, the ID selection and the slice packing depend on the actual values. Only the bench's scenarios, compared against an independent model, can show these.

// File: rtl/flash_query_pkg.sv
`timescale 1ns/1ps
package flash_query_pkg;

  typedef struct packed {
    logic       fire;
    logic       legal;
    logic       idMode;
    logic       byteModeBad;
    logic       repeatByte;
    logic [2:0] bankLog;
    logic [2:0] devLog;
    logic [2:0] accLog;
    logic [3:0] shift;
  } fq_strobe_t;

endpackage

// File: rtl/fq_ctrl.sv
`timescale 1ns/1ps
module fq_ctrl
  import flash_query_pkg::*;
#(
  parameter int CFG_W      = 4,
  parameter int DATA_BYTES = 4
) (
  input  logic             reqValid,
  input  logic             reqIdMode,
  input  logic [CFG_W-1:0] bankBytes,
  input  logic [CFG_W-1:0] devBytes,
  input  logic [CFG_W-1:0] maxDevBytes,
  input  logic [CFG_W-1:0] accBytes,
  output fq_strobe_t       ctl
);

  function automatic logic widthOk(input logic [CFG_W-1:0] v);
    widthOk = (v != '0) && ((v & (v - 1'b1)) == '0) && (int'(v) <= DATA_BYTES);
  endfunction

  function automatic logic [2:0] log2Of(input logic [CFG_W-1:0] v);
    log2Of = '0;
    for (int i = 0; i < CFG_W; i++)
      if (v[i]) log2Of = 3'(i);
  endfunction

  logic [2:0] maxLog;
  logic       allOk;

  always_comb begin
    maxLog = log2Of(maxDevBytes);
    allOk  = widthOk(bankBytes) && widthOk(devBytes) && widthOk(maxDevBytes)
          && widthOk(accBytes) && (devBytes <= bankBytes) && (devBytes <= maxDevBytes);

    ctl             = '0;
    ctl.fire        = reqValid;
    ctl.legal       = allOk;
    ctl.idMode      = reqIdMode;
    ctl.repeatByte  = (devBytes != maxDevBytes);
    ctl.byteModeBad = (devBytes != maxDevBytes) &&
                      !((devBytes == CFG_W'(1)) && (int'(bankBytes) <= 4));
    ctl.bankLog     = log2Of(bankBytes);
    ctl.devLog      = log2Of(devBytes);
    ctl.accLog      = log2Of(accBytes);
    ctl.shift       = 4'(ctl.bankLog) + 4'(maxLog) - 4'(ctl.devLog);
  end

endmodule

// File: rtl/fq_datapath.sv
`timescale 1ns/1ps
module fq_datapath
  import flash_query_pkg::*;
#(
  parameter int          OFS_W        = 16,
  parameter int          DATA_BYTES   = 4,
  parameter int          TABLE_BYTES  = 82,
  parameter int          BLOCKS       = 128,
  parameter int          SECTOR_BYTES = 131072,
  parameter logic [15:0] MFR_ID       = 16'hA25C,
  parameter logic [15:0] DEV_ID       = 16'h3E71
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fq_strobe_t              ctl,
  input  logic [OFS_W-1:0]        reqOffset,
  output logic                    rspValid,
  output logic [8*DATA_BYTES-1:0] rspData
);

  localparam int IDX_W        = OFS_W + 4;
  localparam int SIZE_LOG     = $clog2(BLOCKS) + $clog2(SECTOR_BYTES);
  localparam int BLK_M1       = BLOCKS - 1;
  localparam int SEC_DIV      = SECTOR_BYTES / 256;

  function automatic logic [7:0] qryTable(input logic [7:0] i);
    case (i)
      8'h10:   qryTable = 8'h51;
      8'h11:   qryTable = 8'h52;
      8'h12:   qryTable = 8'h59;
      8'h27:   qryTable = 8'(SIZE_LOG);
      8'h2D:   qryTable = 8'(BLK_M1);
      8'h2E:   qryTable = 8'(BLK_M1 >> 8);
      8'h2F:   qryTable = 8'(SEC_DIV);
      8'h30:   qryTable = 8'(SEC_DIV >> 8);
      default: qryTable = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] idByte(input logic [15:0] id, input logic [3:0] lane);
    idByte = (lane == 4'd0) ? id[7:0] : (lane == 4'd1) ? id[15:8] : 8'h00;
  endfunction

  logic [8*DATA_BYTES-1:0] nextData;

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_byte
    logic [IDX_W-1:0] sliceOfs;
    logic [IDX_W-1:0] idx;
    logic [3:0]       laneSel;
    logic [7:0]       tblByte;
    logic [7:0]       val;

    always_comb begin
      sliceOfs = IDX_W'(reqOffset) + ((IDX_W'(b) >> ctl.bankLog) << ctl.bankLog);
      idx      = sliceOfs >> ctl.shift;
      laneSel  = 4'(b) & ((4'd1 << ctl.devLog) - 4'd1);
      tblByte  = (idx < IDX_W'(TABLE_BYTES)) ? qryTable(idx[7:0]) : 8'h00;
      if (ctl.idMode) begin
        if (idx[7:0] == 8'd0)      val = idByte(MFR_ID, laneSel);
        else if (idx[7:0] == 8'd1) val = idByte(DEV_ID, laneSel);
        else                       val = 8'h00;
      end else if (ctl.byteModeBad) begin
        val = 8'h00;
      end else if (ctl.repeatByte) begin
        val = tblByte;
      end else begin
        val = (laneSel == 4'd0) ? tblByte : 8'h00;
      end
      if (!ctl.legal || (b >= (1 << ctl.accLog))) val = 8'h00;
    end

    assign nextData[8*b +: 8] = val;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= ctl.fire;
      if (ctl.fire) rspData <= nextData;
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fire |=> rspValid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.fire |=> (!rspValid && $stable(rspData)));

  // R9
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fire && !ctl.legal) |=> (rspData == '0));

  // R8
  acc_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fire && ctl.accLog == 3'd0) |=> (rspData[8*DATA_BYTES-1:8] == '0));

endmodule

// File: rtl/flash_query_resp.sv
`timescale 1ns/1ps
module flash_query_resp
  import flash_query_pkg::*;
#(
  parameter int          OFS_W        = 16,
  parameter int          CFG_W        = 4,
  parameter int          DATA_BYTES   = 4,
  parameter int          TABLE_BYTES  = 82,
  parameter int          BLOCKS       = 128,
  parameter int          SECTOR_BYTES = 131072,
  parameter logic [15:0] MFR_ID       = 16'hA25C,
  parameter logic [15:0] DEV_ID       = 16'h3E71
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqIdMode,
  input  logic [OFS_W-1:0]        reqOffset,
  input  logic [CFG_W-1:0]        bankBytes,
  input  logic [CFG_W-1:0]        devBytes,
  input  logic [CFG_W-1:0]        maxDevBytes,
  input  logic [CFG_W-1:0]        accBytes,
  output logic                    rspValid,
  output logic [8*DATA_BYTES-1:0] rspData
);

  fq_strobe_t ctl;

  fq_ctrl #(.CFG_W(CFG_W), .DATA_BYTES(DATA_BYTES)) uCtrl (
    .reqValid    (reqValid),
    .reqIdMode   (reqIdMode),
    .bankBytes   (bankBytes),
    .devBytes    (devBytes),
    .maxDevBytes (maxDevBytes),
    .accBytes    (accBytes),
    .ctl         (ctl)
  );

  fq_datapath #(
    .OFS_W(OFS_W), .DATA_BYTES(DATA_BYTES), .TABLE_BYTES(TABLE_BYTES),
    .BLOCKS(BLOCKS), .SECTOR_BYTES(SECTOR_BYTES), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqOffset (reqOffset),
    .rspValid  (rspValid),
    .rspData   (rspData)
  );

endmodule

// File: tb/flash_query_resp_test.sv
`timescale 1ns/1ps
module flash_query_resp_test;

  localparam int          BLOCKS  = 128;
  localparam int          SECTOR  = 131072;
  localparam logic [15:0] MFR     = 16'hA25C;
  localparam logic [15:0] DEV     = 16'h3E71;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqIdMode = 1'b0;
  logic [15:0] reqOffset = '0;
  logic [3:0]  bankBytes = 4'd1, devBytes = 4'd1, maxDevBytes = 4'd1, accBytes = 4'd1;
  logic        rspValid;
  logic [31:0] rspData;

  int tests = 0;
  int fails = 0;

  bit          pendValid = 1'b0;
  logic [31:0] pendData  = '0;
  string       pendTag   = "R10";
  logic [31:0] lastData  = '0;

  always #5 clk = ~clk;

  flash_query_resp #(.BLOCKS(BLOCKS), .SECTOR_BYTES(SECTOR), .MFR_ID(MFR), .DEV_ID(DEV)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIdMode(reqIdMode),
    .reqOffset(reqOffset), .bankBytes(bankBytes), .devBytes(devBytes),
    .maxDevBytes(maxDevBytes), .accBytes(accBytes),
    .rspValid(rspValid), .rspData(rspData)
  );

  function automatic int lg(input int v);
    int r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  function automatic bit okW(input int v);
    return v > 0 && (v & (v - 1)) == 0 && v <= 4;
  endfunction

  function automatic int tab(input int i);
    case (i)
      16: return 'h51;
      17: return 'h52;
      18: return 'h59;
      39: return lg(BLOCKS) + lg(SECTOR);
      45: return (BLOCKS - 1) % 256;
      46: return (BLOCKS - 1) / 256;
      47: return (SECTOR / 256) % 256;
      48: return (SECTOR / 256) / 256;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] model(input bit idm, input int off, input int bk,
                                        input int dw, input int mx, input int acc);
    logic [31:0] res = '0;
    int sh;
    if (!okW(bk) || !okW(dw) || !okW(mx) || !okW(acc) || dw > bk || dw > mx) return '0;
    if (!idm && dw != mx && !(dw == 1 && bk <= 4)) return '0;
    sh = lg(bk) + lg(mx) - lg(dw);
    for (int n = 0; n < acc; n++) begin
      int idx  = (off + (n / bk) * bk) >> sh;
      int lane = n % dw;
      int by   = 0;
      if (idm) begin
        int id = -1;
        if (idx % 256 == 0) id = MFR;
        else if (idx % 256 == 1) id = DEV;
        if (id >= 0 && lane < 2) by = (id >> (8 * lane)) & 255;
      end else begin
        int t = (idx < 82) ? tab(idx) : 0;
        by = (dw < mx) ? t : ((lane == 0) ? t : 0);
      end
      res[8*n +: 8] = 8'(by);
    end
    return res;
  endfunction

  task automatic compareNow();
    tests++;
    if (rspValid !== pendValid) begin
      fails++;
      $display("FAIL %s rspValid actual=%0b expected=%0b", pendTag, rspValid, pendValid);
    end
    tests++;
    if (pendValid) begin
      if (rspData !== pendData) begin
        fails++;
        $display("FAIL %s rspData actual=%h expected=%h", pendTag, rspData, pendData);
      end
      lastData = pendData;
    end else if (rspData !== lastData) begin
      fails++;
      $display("FAIL R10 hold rspData actual=%h expected=%h", rspData, lastData);
    end
  endtask

  task automatic step(input bit v, input bit idm, input int off, input int bk,
                      input int dw, input int mx, input int acc, input string tag);
    @(negedge clk);
    compareNow();
    reqValid    = v;
    reqIdMode   = idm;
    reqOffset   = 16'(off);
    bankBytes   = 4'(bk);
    devBytes    = 4'(dw);
    maxDevBytes = 4'(mx);
    accBytes    = 4'(acc);
    pendValid   = v;
    pendTag     = v ? tag : "R10";
    if (v) pendData = model(idm, off, bk, dw, mx, acc);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 0, 1, 1, 1, 1, "R10");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R11: state during reset
    @(negedge clk);
    tests++;
    if (rspValid !== 1'b0 || rspData !== '0) begin
      fails++;
      $display("FAIL R11 reset actual=%0b/%h expected=0/0", rspValid, rspData);
    end
    @(negedge clk);
    rstN = 1'b1;
    // R11: after reset, no request yet
    idle();
    // R3 table content, single byte-wide device
    step(1, 0, 'h10, 1, 1, 1, 1, "R3");
    step(1, 0, 'h11, 1, 1, 1, 1, "R3");
    step(1, 0, 'h12, 1, 1, 1, 1, "R3");
    step(1, 0, 'h27, 1, 1, 1, 1, "R3");
    step(1, 0, 'h2D, 1, 1, 1, 1, "R3");
    step(1, 0, 'h2E, 1, 1, 1, 1, "R3");
    step(1, 0, 'h2F, 1, 1, 1, 1, "R3");
    step(1, 0, 'h30, 1, 1, 1, 1, "R3");
    step(1, 0, 'h05, 1, 1, 1, 1, "R3");
    // R2 out of table
    step(1, 0, 'h51, 1, 1, 1, 1, "R2");
    step(1, 0, 'h52, 1, 1, 1, 1, "R2");
    step(1, 0, 'h100, 1, 1, 1, 1, "R2");
    // R1 / R5 rescaling with native-width devices
    step(1, 0, 'h20, 2, 2, 2, 2, "R1");
    step(1, 0, 'h44, 4, 2, 2, 4, "R5");
    step(1, 0, 'h40, 4, 1, 1, 4, "R5");
    // R4 byte mode of wider parts
    step(1, 0, 'h40, 2, 1, 2, 2, "R4");
    step(1, 0, 'h80, 4, 1, 2, 4, "R4");
    step(1, 0, 'h48, 1, 1, 2, 1, "R4");
    step(1, 0, 'h80, 4, 2, 4, 4, "R4");
    // R6 identification
    step(1, 1, 0, 1, 1, 1, 1, "R6");
    step(1, 1, 1, 1, 1, 1, 1, "R6");
    step(1, 1, 2, 1, 1, 1, 1, "R6");
    step(1, 1, 'h100, 1, 1, 1, 1, "R6");
    step(1, 1, 0, 4, 2, 2, 4, "R6");
    step(1, 1, 4, 4, 2, 2, 4, "R6");
    step(1, 1, 8, 4, 1, 2, 4, "R6");
    // R7 wide access slices
    step(1, 0, 'h10, 1, 1, 1, 4, "R7");
    step(1, 0, 'h20, 2, 2, 2, 4, "R7");
    step(1, 1, 0, 2, 2, 2, 4, "R7");
    // R8 access narrower than bank
    step(1, 0, 'h40, 4, 1, 1, 1, "R8");
    step(1, 0, 'h40, 4, 1, 1, 2, "R8");
    // R9 illegal configurations
    step(1, 0, 'h10, 3, 1, 1, 1, "R9");
    step(1, 0, 'h10, 1, 0, 1, 1, "R9");
    step(1, 1, 0, 1, 2, 2, 1, "R9");
    step(1, 0, 'h10, 1, 1, 1, 3, "R9");
    step(1, 1, 0, 2, 2, 1, 2, "R9");
    step(1, 0, 'h10, 8, 1, 1, 1, "R9");
    // R10 idle hold and back-to-back
    idle();
    idle();
    step(1, 0, 'h11, 1, 1, 1, 1, "R10");
    step(1, 0, 'h12, 1, 1, 1, 1, "R10");
    idle();
    idle();
    @(negedge clk);
    compareNow();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule